// File: doc/BRIEF.md
# Line-Address Coalescing Miss Table

This block collects the per-lane memory packets of vector instructions and folds every packet that shares an instruction, a cache-line address and an access type into one coalesced request. Each coalesced request takes one slot of a small table. The slot records the instruction's sequence number, the line address, the access type and a mask of the lanes it covers. Once the last packet of an instruction has been accepted, the table sends that instruction's requests to memory on an issue port.

Requests from different instructions are never merged, even when they target the same line. They form an age-ordered queue per line address, and only the oldest request in a line's queue may be issued. A response names a line and an access type. It retires the oldest sent request of that line, returns the request's lane mask and sequence number on the hit port one cycle later, and frees the slot. A store acknowledgement frees its slot at once and does not wait for the store's final completion.

Two limits apply. The number of slots bounds the requests in flight. A coalescing window bounds how many instructions may have packets under assembly at the same time. When a limit is reached the offered packet is held off with `in_ready` low until room appears.

Top module: `cm_coalesce_table`

## Requirements
- R1: A packet whose instruction, line address and access type (`in_store`: 0 load, 1 store) equal those of a request still being assembled is merged into it. Its lane bit (bit `in_lane` of the mask) is ORed into that request's lane mask, and no new slot is taken.
- R2: A packet whose instruction differs from that of every request being assembled for its line takes a new slot, even when the line address matches.
- R3: Requests to the same line are issued and retired oldest first. A younger request to a line is not offered on the issue port while an older request to that line still holds a slot. It becomes eligible in the cycle after the older one retires.
- R4: The table holds at most NENT requests. When all slots are taken, a packet that would need a new slot is refused (`in_ready` low). A packet that merges into an existing request is still accepted.
- R5: A request is offered on the issue port only after the packet flagged `in_last` of its instruction has been accepted. Among the eligible requests the lowest slot index goes first. A request counts as issued when `out_valid` and `out_ready` are both high at a clock edge.
- R6: A response (`rsp_valid`) whose line and type match the oldest issued request of that line retires that request. In the next cycle `hit_valid` is high, with that request's lane mask, sequence number and type on `hit_lanes`, `hit_seq` and `hit_store`.
- R7: A store acknowledgement (`rsp_store` = 1) releases its slot at once. A response whose line or type matches no issued head request is ignored: no hit is produced and the table is unchanged.
- R8: At most WIN instructions may have packets under assembly at once. A non-last packet of a further instruction is refused until an earlier instruction delivers its last packet.
- R9: While reset is asserted and after it is released, with nothing offered, `in_ready` is high and `out_valid` and `hit_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Lane packet offered |
| in_ready | output | 1 | Lane packet accepted this cycle |
| in_seq | input | SEQ_W | Instruction sequence number of the packet |
| in_lane | input | LANE_W | Lane index of the packet |
| in_line | input | LINE_W | Cache-line address of the packet |
| in_store | input | 1 | Access type, 1 for store |
| in_last | input | 1 | Final packet of the instruction |
| out_valid | output | 1 | Coalesced request offered to memory |
| out_ready | input | 1 | Memory takes the offered request |
| out_line | output | LINE_W | Line address of the offered request |
| out_seq | output | SEQ_W | Sequence number of the offered request |
| out_store | output | 1 | Access type of the offered request |
| rsp_valid | input | 1 | Response or store acknowledgement arrives |
| rsp_line | input | LINE_W | Line address of the response |
| rsp_store | input | 1 | Response type, 1 for store acknowledgement |
| hit_valid | output | 1 | Lanes of a retired request are answered |
| hit_lanes | output | LANES | Lane mask of the retired request |
| hit_seq | output | SEQ_W | Sequence number of the retired request |
| hit_store | output | 1 | Access type of the retired request |

## Verification
The bench sends two instructions to one line and checks that the younger one stays off the issue port until the older one is answered. A table that merged across instructions would return a single combined lane mask, and one that ignored age would issue both at once. It fills every slot and then offers both a merging packet and a packet that needs a new slot. A wrong capacity check would either refuse the merge or accept the new packet. It sends a load response to an issued store and to a line that is not in the table, and a design that matched on line alone would answer the wrong request. It also opens more instructions than the window allows and checks that the extra one stalls only until an earlier instruction completes.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [1:0] {
    SL_FREE  = 2'd0,
    SL_OPEN  = 2'd1,
    SL_READY = 2'd2,
    SL_SENT  = 2'd3
  } slot_st_e;
endpackage

// File: rtl/cm_pick.sv
module cm_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cm_lookup.sv
module cm_lookup #(
  parameter int NENT   = 4,
  parameter int LINE_W = 8,
  parameter int SEQ_W  = 4,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNT_W = $clog2(NENT + 1)
) (
  input  cm_pkg::slot_st_e    st      [NENT],
  input  logic [LINE_W-1:0]   line_q  [NENT],
  input  logic [SEQ_W-1:0]    seq_q   [NENT],
  input  logic                store_q [NENT],
  input  logic [SEQ_W-1:0]    q_seq,
  input  logic [LINE_W-1:0]   q_line,
  input  logic                q_store,
  output logic                merge_hit,
  output logic [IDX_W-1:0]    merge_idx,
  output logic                free_any,
  output logic [IDX_W-1:0]    free_idx,
  output logic [CNT_W-1:0]    line_cnt,
  output logic [CNT_W-1:0]    occ
);
  logic [NENT-1:0] merge_vec, free_vec, line_vec;

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign merge_vec[g] = (st[g] == cm_pkg::SL_OPEN) && (seq_q[g] == q_seq) &&
                          (line_q[g] == q_line) && (store_q[g] == q_store);
    assign free_vec[g]  = (st[g] == cm_pkg::SL_FREE);
    assign line_vec[g]  = (st[g] != cm_pkg::SL_FREE) && (line_q[g] == q_line);
  end

  cm_pick #(.N(NENT), .IW(IDX_W)) merge_pick_i (
    .req(merge_vec), .any(merge_hit), .idx(merge_idx));
  cm_pick #(.N(NENT), .IW(IDX_W)) free_pick_i (
    .req(free_vec), .any(free_any), .idx(free_idx));

  always_comb begin
    line_cnt = '0;
    occ      = '0;
    for (int i = 0; i < NENT; i++) begin
      line_cnt = line_cnt + CNT_W'(line_vec[i]);
      occ      = occ + CNT_W'(!free_vec[i]);
    end
  end
endmodule

// File: rtl/cm_window.sv
module cm_window #(
  parameter int WIN   = 2,
  parameter int SEQ_W = 4,
  localparam int WIW  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [SEQ_W-1:0] seq,
  input  logic             last,
  output logic             seq_ok
);
  logic [WIN-1:0]   open_v, open_v_n, hit_vec, free_vec;
  logic [SEQ_W-1:0] open_seq [WIN];
  logic             hit_any, free_any, load_en;
  logic [WIW-1:0]   hit_idx, free_idx;

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    assign hit_vec[g]  = open_v[g] && (open_seq[g] == seq);
    assign free_vec[g] = !open_v[g];
  end

  cm_pick #(.N(WIN), .IW(WIW)) hit_pick_i (
    .req(hit_vec), .any(hit_any), .idx(hit_idx));
  cm_pick #(.N(WIN), .IW(WIW)) free_pick_i (
    .req(free_vec), .any(free_any), .idx(free_idx));

  assign seq_ok = hit_any || free_any || last;

  always_comb begin
    open_v_n = open_v;
    load_en  = 1'b0;
    if (acc) begin
      if (hit_any && last) begin
        open_v_n[hit_idx] = 1'b0;
      end else if (!hit_any && !last) begin
        open_v_n[free_idx] = 1'b1;
        load_en            = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_v <= '0;
    else if (acc) open_v <= open_v_n;
  end

  always_ff @(posedge clk) begin
    if (load_en) open_seq[free_idx] <= seq;
  end
endmodule

// File: rtl/cm_coalesce_table.sv
module cm_coalesce_table #(
  parameter int NENT   = 4,
  parameter int LANES  = 8,
  parameter int LINE_W = 8,
  parameter int SEQ_W  = 4,
  parameter int WIN    = 2,
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int IDX_W  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNT_W  = $clog2(NENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [LANE_W-1:0] in_lane,
  input  logic [LINE_W-1:0] in_line,
  input  logic              in_store,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LINE_W-1:0] out_line,
  output logic [SEQ_W-1:0]  out_seq,
  output logic              out_store,
  input  logic              rsp_valid,
  input  logic [LINE_W-1:0] rsp_line,
  input  logic              rsp_store,
  output logic              hit_valid,
  output logic [LANES-1:0]  hit_lanes,
  output logic [SEQ_W-1:0]  hit_seq,
  output logic              hit_store
);
  import cm_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  // slot state
  slot_st_e          st      [NENT];
  slot_st_e          st_n    [NENT];
  logic [LINE_W-1:0] line_q  [NENT];
  logic [SEQ_W-1:0]  seq_q   [NENT];
  logic              store_q [NENT];
  logic [LANES-1:0]  lanes_q [NENT];
  logic [LANES-1:0]  lanes_n [NENT];
  logic [IDX_W-1:0]  qpos_q  [NENT];
  logic [IDX_W-1:0]  qpos_n  [NENT];

  logic              merge_hit, free_any, seq_ok, acc, alloc;
  logic [IDX_W-1:0]  merge_idx, free_idx;
  logic [CNT_W-1:0]  line_cnt, occ;

  cm_lookup #(.NENT(NENT), .LINE_W(LINE_W), .SEQ_W(SEQ_W)) lookup_i (
    .st(st), .line_q(line_q), .seq_q(seq_q), .store_q(store_q),
    .q_seq(in_seq), .q_line(in_line), .q_store(in_store),
    .merge_hit(merge_hit), .merge_idx(merge_idx),
    .free_any(free_any), .free_idx(free_idx),
    .line_cnt(line_cnt), .occ(occ));

  cm_window #(.WIN(WIN), .SEQ_W(SEQ_W)) window_i (
    .clk(clk), .rst_n(rst_q), .acc(acc), .seq(in_seq), .last(in_last),
    .seq_ok(seq_ok));

  assign in_ready = (merge_hit || free_any) && seq_ok;
  assign acc      = in_valid && in_ready;
  assign alloc    = acc && !merge_hit;

  // issue and response selection
  logic [NENT-1:0]  iss_vec, rsp_vec;
  logic             iss_any, rsp_hit;
  logic [IDX_W-1:0] iss_idx, rsp_idx;

  for (genvar g = 0; g < NENT; g++) begin : g_sel
    assign iss_vec[g] = (st[g] == SL_READY) && (qpos_q[g] == '0);
    assign rsp_vec[g] = rsp_valid && (st[g] == SL_SENT) && (qpos_q[g] == '0) &&
                        (line_q[g] == rsp_line) && (store_q[g] == rsp_store);
  end

  cm_pick #(.N(NENT), .IW(IDX_W)) iss_pick_i (
    .req(iss_vec), .any(iss_any), .idx(iss_idx));
  cm_pick #(.N(NENT), .IW(IDX_W)) rsp_pick_i (
    .req(rsp_vec), .any(rsp_hit), .idx(rsp_idx));

  assign out_valid = iss_any;
  assign out_line  = line_q[iss_idx];
  assign out_seq   = seq_q[iss_idx];
  assign out_store = store_q[iss_idx];

  logic [LINE_W-1:0] ret_line;
  logic              ret_same;
  logic [IDX_W-1:0]  alloc_qpos;
  logic              st_en;

  assign ret_line   = line_q[rsp_idx];
  assign ret_same   = rsp_hit && (ret_line == in_line);
  assign alloc_qpos = IDX_W'(line_cnt) - IDX_W'(ret_same);
  assign st_en      = acc || rsp_hit || (iss_any && out_ready);

  // next-state
  always_comb begin
    for (int i = 0; i < NENT; i++) begin
      st_n[i]    = st[i];
      lanes_n[i] = lanes_q[i];
      qpos_n[i]  = qpos_q[i];
    end
    if (rsp_hit) begin
      st_n[rsp_idx] = SL_FREE;
      for (int i = 0; i < NENT; i++) begin
        if (IDX_W'(i) != rsp_idx && st[i] != SL_FREE && line_q[i] == ret_line)
          qpos_n[i] = qpos_q[i] - IDX_W'(1);
      end
    end
    if (iss_any && out_ready) st_n[iss_idx] = SL_SENT;
    if (acc) begin
      if (merge_hit) begin
        lanes_n[merge_idx] = lanes_q[merge_idx] | (LANES'(1) << in_lane);
      end else begin
        st_n[free_idx]    = SL_OPEN;
        lanes_n[free_idx] = LANES'(1) << in_lane;
        qpos_n[free_idx]  = alloc_qpos;
      end
      if (in_last) begin
        for (int i = 0; i < NENT; i++) begin
          if (st_n[i] == SL_OPEN &&
              ((st[i] == SL_OPEN && seq_q[i] == in_seq) || (alloc && IDX_W'(i) == free_idx)))
            st_n[i] = SL_READY;
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < NENT; i++) st[i] <= SL_FREE;
      hit_valid <= 1'b0;
    end else begin
      if (st_en) begin
        for (int i = 0; i < NENT; i++) st[i] <= st_n[i];
      end
      hit_valid <= rsp_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      line_q[free_idx]  <= in_line;
      seq_q[free_idx]   <= in_seq;
      store_q[free_idx] <= in_store;
    end
    if (acc || rsp_hit) begin
      for (int i = 0; i < NENT; i++) begin
        lanes_q[i] <= lanes_n[i];
        qpos_q[i]  <= qpos_n[i];
      end
    end
    if (rsp_hit) begin
      hit_lanes <= lanes_q[rsp_idx];
      hit_seq   <= seq_q[rsp_idx];
      hit_store <= store_q[rsp_idx];
    end
  end
endmodule

// File: rtl/cm_coalesce_chk.sv
module cm_coalesce_chk #(
  parameter int NENT  = 4,
  parameter int LANES = 8,
  localparam int CNT_W = $clog2(NENT + 1)
) (
  input logic             clk,
  input logic             rst_q,
  input logic             rsp_valid,
  input logic             hit_valid,
  input logic [LANES-1:0] hit_lanes,
  input logic             out_valid,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CNT_W-1:0] occ
);
  // R6: a hit only follows a response presented one cycle earlier
  a_r6_hit_after_rsp: assert property (@(posedge clk) disable iff (!rst_q)
    hit_valid |-> $past(rsp_valid));

  // R1: every retired request covers at least one lane
  a_r1_hit_has_lanes: assert property (@(posedge clk) disable iff (!rst_q)
    hit_valid |-> hit_lanes != '0);

  // R4: occupancy grows by at most one slot per cycle
  a_r4_occ_step: assert property (@(posedge clk) disable iff (!rst_q)
    ##1 (occ <= $past(occ) + CNT_W'(1)));

  // R4: a full table with a packet taken cannot exceed capacity next cycle
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_q)
    (occ == CNT_W'(NENT) && in_valid && in_ready) |=> occ <= CNT_W'(NENT));

  // R5: an empty table offers nothing to memory
  a_r5_idle_no_issue: assert property (@(posedge clk) disable iff (!rst_q)
    occ == '0 |-> !out_valid);
endmodule

bind cm_coalesce_table cm_coalesce_chk #(.NENT(NENT), .LANES(LANES)) chk_i (
  .clk(clk), .rst_q(rst_q), .rsp_valid(rsp_valid), .hit_valid(hit_valid),
  .hit_lanes(hit_lanes), .out_valid(out_valid), .in_valid(in_valid),
  .in_ready(in_ready), .occ(occ));

// File: tb/cm_coalesce_table_tb_top.sv
`timescale 1ns/1ps
module cm_coalesce_table_tb_top;
  localparam int NENT = 4, LANES = 8, LINE_W = 8, SEQ_W = 4, WIN = 2, LANE_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid = 0, in_store = 0, in_last = 0, out_ready = 0, rsp_valid = 0, rsp_store = 0;
  logic [SEQ_W-1:0] in_seq = '0;
  logic [LANE_W-1:0] in_lane = '0;
  logic [LINE_W-1:0] in_line = '0, rsp_line = '0;
  logic in_ready, out_valid, out_store, hit_valid, hit_store;
  logic [LINE_W-1:0] out_line;
  logic [SEQ_W-1:0] out_seq, hit_seq;
  logic [LANES-1:0] hit_lanes;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cm_coalesce_table #(.NENT(NENT), .LANES(LANES), .LINE_W(LINE_W), .SEQ_W(SEQ_W), .WIN(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_seq(in_seq),
    .in_lane(in_lane), .in_line(in_line), .in_store(in_store), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line), .out_seq(out_seq),
    .out_store(out_store), .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_store(rsp_store),
    .hit_valid(hit_valid), .hit_lanes(hit_lanes), .hit_seq(hit_seq), .hit_store(hit_store));

  // packet vectors: seq, lane, line, store, last, expected in_ready
  localparam int PW = 18;
  localparam logic [PW-1:0] PKT_TAB [6] = '{
    {4'd4, 3'd0, 8'h40, 1'b0, 1'b0, 1'b1},
    {4'd4, 3'd1, 8'h41, 1'b0, 1'b0, 1'b1},
    {4'd4, 3'd2, 8'h42, 1'b0, 1'b0, 1'b1},
    {4'd4, 3'd3, 8'h43, 1'b0, 1'b0, 1'b1},
    {4'd4, 3'd4, 8'h40, 1'b0, 1'b1, 1'b1},   // merge into a full table
    {4'd5, 3'd0, 8'h50, 1'b0, 1'b1, 1'b0}    // needs a slot: refused
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] s, input logic [2:0] ln, input logic [7:0] a,
                      input logic st, input logic lst, input logic exp_rdy, input string req);
    @(negedge clk);
    in_seq = s; in_lane = ln; in_line = a; in_store = st; in_last = lst; in_valid = 1'b1;
    #1 chk(req, in_ready, exp_rdy);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic take(input logic [7:0] a, input logic [3:0] s, input logic st, input string req);
    @(negedge clk);
    #1;
    chk(req, out_valid, 1'b1);
    chk(req, out_line, a);
    chk(req, out_seq, s);
    chk(req, out_store, st);
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic respond(input logic [7:0] a, input logic st, input logic exp_hit,
                         input logic [7:0] exp_lanes, input logic [3:0] exp_seq, input string req);
    @(negedge clk);
    rsp_line = a; rsp_store = st; rsp_valid = 1'b1;
    @(posedge clk);
    #1 rsp_valid = 1'b0;
    @(negedge clk);
    chk(req, hit_valid, exp_hit);
    if (exp_hit) begin
      chk(req, hit_lanes, exp_lanes);
      chk(req, hit_seq, exp_seq);
      chk(req, hit_store, st);
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    #1 chk(req, out_valid, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 ready in reset", in_ready, 1'b1);
    chk("R9 out_valid in reset", out_valid, 1'b0);
    chk("R9 hit_valid in reset", hit_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 ready after reset", in_ready, 1'b1);
    chk("R9 idle after reset", out_valid, 1'b0);

    // R1 / R5: merge within one instruction, issue after last packet
    send(4'd1, 3'd0, 8'h10, 1'b0, 1'b0, 1'b1, "R1 pkt0");
    send(4'd1, 3'd1, 8'h10, 1'b0, 1'b0, 1'b1, "R1 pkt1");
    idle_check("R5 no issue before last");
    send(4'd1, 3'd2, 8'h20, 1'b0, 1'b1, 1'b1, "R1 pkt2 last");
    take(8'h10, 4'd1, 1'b0, "R5 issue slot0");
    take(8'h20, 4'd1, 1'b0, "R5 issue slot1");
    idle_check("R5 nothing left");
    respond(8'h20, 1'b0, 1'b1, 8'h04, 4'd1, "R6 line20 hit");
    respond(8'h10, 1'b0, 1'b1, 8'h03, 4'd1, "R1 merged mask");

    // R2 / R3: two instructions, same line, oldest first
    send(4'd2, 3'd0, 8'h30, 1'b0, 1'b1, 1'b1, "R2 older");
    send(4'd3, 3'd1, 8'h30, 1'b0, 1'b1, 1'b1, "R2 younger");
    take(8'h30, 4'd2, 1'b0, "R3 head issues");
    idle_check("R3 younger held");
    respond(8'h30, 1'b0, 1'b1, 8'h01, 4'd2, "R2 older lanes only");
    take(8'h30, 4'd3, 1'b0, "R3 younger after retire");
    respond(8'h30, 1'b0, 1'b1, 8'h02, 4'd3, "R2 younger lanes");

    // R4: capacity, vector table
    for (int k = 0; k < 6; k++) begin
      send(PKT_TAB[k][17:14], PKT_TAB[k][13:11], PKT_TAB[k][10:3], PKT_TAB[k][2],
           PKT_TAB[k][1], PKT_TAB[k][0], "R4 table vector");
    end
    take(8'h40, 4'd4, 1'b0, "R4 issue 40");
    take(8'h41, 4'd4, 1'b0, "R4 issue 41");
    take(8'h42, 4'd4, 1'b0, "R4 issue 42");
    take(8'h43, 4'd4, 1'b0, "R4 issue 43");
    respond(8'h41, 1'b0, 1'b1, 8'h02, 4'd4, "R6 retire 41");
    respond(8'h40, 1'b0, 1'b1, 8'h11, 4'd4, "R4 merged while full");
    send(4'd5, 3'd0, 8'h50, 1'b0, 1'b1, 1'b1, "R4 accepted after free");
    take(8'h50, 4'd5, 1'b0, "R4 issue 50");
    respond(8'h42, 1'b0, 1'b1, 8'h04, 4'd4, "R6 retire 42");
    respond(8'h43, 1'b0, 1'b1, 8'h08, 4'd4, "R6 retire 43");
    respond(8'h50, 1'b0, 1'b1, 8'h01, 4'd5, "R6 retire 50");

    // R7: store released on first ack, mismatches ignored
    send(4'd7, 3'd0, 8'h70, 1'b1, 1'b1, 1'b1, "R7 store pkt");
    take(8'h70, 4'd7, 1'b1, "R7 store issue");
    respond(8'h70, 1'b0, 1'b0, 8'h00, 4'd0, "R7 load rsp to store ignored");
    respond(8'hFF, 1'b0, 1'b0, 8'h00, 4'd0, "R7 unknown line ignored");
    respond(8'h70, 1'b1, 1'b1, 8'h01, 4'd7, "R7 store ack");

    // R8: coalescing window
    send(4'd8, 3'd0, 8'h80, 1'b0, 1'b0, 1'b1, "R8 open seq8");
    send(4'd9, 3'd0, 8'h90, 1'b0, 1'b0, 1'b1, "R8 open seq9");
    send(4'd10, 3'd0, 8'hA0, 1'b0, 1'b0, 1'b0, "R8 third refused");
    send(4'd8, 3'd1, 8'h80, 1'b0, 1'b1, 1'b1, "R8 close seq8");
    send(4'd10, 3'd0, 8'hA0, 1'b0, 1'b0, 1'b1, "R8 third accepted");
    send(4'd9, 3'd1, 8'h90, 1'b0, 1'b1, 1'b1, "R8 close seq9");
    send(4'd10, 3'd1, 8'hA0, 1'b0, 1'b1, 1'b1, "R8 close seq10");
    take(8'h80, 4'd8, 1'b0, "R8 issue 80");
    take(8'h90, 4'd9, 1'b0, "R8 issue 90");
    take(8'hA0, 4'd10, 1'b0, "R8 issue A0");
    respond(8'h90, 1'b0, 1'b1, 8'h03, 4'd9, "R8 retire 90");
    respond(8'hA0, 1'b0, 1'b1, 8'h03, 4'd10, "R8 retire A0");
    respond(8'h80, 1'b0, 1'b1, 8'h03, 4'd8, "R8 retire 80");
    idle_check("R6 table drained");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule